// File: doc/BRIEF.md
# Pipelined Flush-to-Zero Floating Point Adder

This block adds or subtracts two binary floating point numbers in the standard single-precision layout. The exponent and fraction widths are parameters, and the defaults give the 32-bit format. A new operation can enter on every clock. Its result, together with three exception flags, leaves the block exactly four cycles later.

The datapath works in four steps. It first orders the operands by magnitude. It then right-aligns the smaller significand with a logarithmic shifter whose stages shift by 1, 2, 4, 8 and 16, and combines the two significands in a plain integer adder. A leading-one search then drives a normalizing shift. Last, the block rounds, packs the result and selects any special result.

Only round-to-nearest-even is offered. Subnormal operands count as zero. A result that would be subnormal is replaced by a zero with the result's sign. Infinities and NaNs follow the usual rules, and every NaN result is the single canonical quiet NaN.

Top module: `ftz_fp_adder`

## Requirements
- R1: A result with `out_valid` high appears on the fourth rising edge counted from the edge that samples `in_valid` high, and `out_valid` stays low four edges after an idle input cycle. One operation is accepted per cycle.
- R2: For finite, nonzero, non-subnormal operands whose result is in the normal range, `result` is the exact sum rounded to nearest with ties to even, and no flag is raised.
- R3: An operand whose exponent field is 0 is treated as a zero of the same sign, whatever its fraction bits hold.
- R4: When the rounded result has a magnitude below the smallest normal number but is not exactly zero, `result` is a zero carrying the result's sign (exponent and fraction fields all 0) and `flag_underflow` is 1.
- R5: When the rounded result exceeds the largest finite value, `result` is an infinity of the result's sign (exponent field all ones, fraction 0) and `flag_overflow` is 1.
- R6: If either operand is a NaN (exponent all ones, fraction nonzero), `result` is the canonical quiet NaN and no flag is raised. The canonical quiet NaN has sign 0, exponent all ones and only the fraction's top bit set (0x7FC00000 in the default format).
- R7: Adding infinities of opposite effective sign gives the canonical quiet NaN with `flag_invalid` set to 1.
- R8: An infinity combined with a finite value, or with an infinity of the same effective sign, gives that infinity, and no flag is raised.
- R9: An exact zero sum is +0, except when both operands are zeros of the same effective sign, in which case it is a zero of that sign.
- R10: While `rst_n` is low, `out_valid`, `result` and all three flags read 0.
- R11: With `subtract` at 1 the block computes `op_a - op_b` by inverting the sign of `op_b`. With `subtract` at 0 it computes `op_a + op_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | EW+MW+1 | First operand |
| op_b | input | EW+MW+1 | Second operand |
| subtract | input | 1 | 1 selects a minus b |
| out_valid | output | 1 | Result present this cycle |
| result | output | EW+MW+1 | Rounded sum or difference |
| flag_invalid | output | 1 | Invalid operation, infinity minus infinity |
| flag_overflow | output | 1 | Result rounded beyond the finite range |
| flag_underflow | output | 1 | Nonzero result flushed to zero |

## Verification
Two cases are the hardest to reach from the ports. The first is a subtraction of two close normal values whose difference falls below the smallest normal and must be flushed. The second is a rounding carry that pushes the exponent into overflow. Both arise only for narrow operand relationships. The bench therefore uses a 12-bit format (5 exponent bits, 6 fraction bits), sweeps every first operand, and pairs each one with itself under both operations, with a fixed set of special values, and with scattered second operands. A reference built on exact integer sums then rounds each result independently of the datapath.

// File: rtl/ftz_fp_adder.sv
module ftz_fp_adder #(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [EW+MW:0] op_a,
  input  logic [EW+MW:0] op_b,
  input  logic           subtract,
  output logic           out_valid,
  output logic [EW+MW:0] result,
  output logic           flag_invalid,
  output logic           flag_overflow,
  output logic           flag_underflow
);
  localparam int W   = EW + MW + 1;
  localparam int AW  = MW + 4;
  localparam int SW  = MW + 5;
  localparam int SHW = $clog2(AW + 1);
  localparam int XW  = EW + 2;
  localparam int CW  = W + 5;
  localparam logic [EW-1:0] EMAX = {EW{1'b1}};
  localparam logic [W-1:0]  QNAN = {1'b0, EMAX, 1'b1, {(MW-1){1'b0}}};

  // control word: valid, special, invalid, sign, effective subtract, special result
  logic [CW-1:0] ctl1, ctl2, ctl3;

  // ---------------- stage 1: classify and order ----------------
  logic sa, sb, a_zero, b_zero, a_inf, b_inf, a_nan, b_nan, a_big, nan_any, inv_in;
  logic [W-2:0] mag_a, mag_b, mag_l, mag_s;
  logic [W-1:0] spec_res;
  logic [EW-1:0] exp1, dif1, exp2;
  logic [MW:0]   sigl1, sigs1;

  assign sa      = op_a[W-1];
  assign sb      = op_b[W-1] ^ subtract;
  assign a_zero  = op_a[W-2:MW] == '0;
  assign b_zero  = op_b[W-2:MW] == '0;
  assign a_inf   = (op_a[W-2:MW] == EMAX) && (op_a[MW-1:0] == '0);
  assign b_inf   = (op_b[W-2:MW] == EMAX) && (op_b[MW-1:0] == '0);
  assign a_nan   = (op_a[W-2:MW] == EMAX) && (op_a[MW-1:0] != '0);
  assign b_nan   = (op_b[W-2:MW] == EMAX) && (op_b[MW-1:0] != '0);
  assign nan_any = a_nan | b_nan;
  assign inv_in  = a_inf & b_inf & (sa != sb);
  assign mag_a   = a_zero ? '0 : op_a[W-2:0];
  assign mag_b   = b_zero ? '0 : op_b[W-2:0];
  assign a_big   = mag_a >= mag_b;
  assign mag_l   = a_big ? mag_a : mag_b;
  assign mag_s   = a_big ? mag_b : mag_a;
  assign spec_res = (nan_any | inv_in) ? QNAN :
                    a_inf ? {sa, EMAX, {MW{1'b0}}} : {sb, EMAX, {MW{1'b0}}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl1 <= '0;
    else ctl1 <= {in_valid, nan_any | a_inf | b_inf, inv_in, a_big ? sa : sb, sa ^ sb, spec_res};

  always_ff @(posedge clk) begin
    exp1  <= mag_l[W-2:MW];
    dif1  <= mag_l[W-2:MW] - mag_s[W-2:MW];
    sigl1 <= (mag_l[W-2:MW] == '0) ? '0 : {1'b1, mag_l[MW-1:0]};
    sigs1 <= (mag_s[W-2:MW] == '0) ? '0 : {1'b1, mag_s[MW-1:0]};
  end

  // ---------------- stage 2: align and add ----------------
  logic [SHW-1:0] sh;
  logic [AW-1:0]  stg [SHW+1];
  logic [SW-1:0]  lng, shr, sum_c, sum2;

  assign sh     = (int'(dif1) > AW) ? SHW'(AW) : SHW'(dif1);
  assign stg[0] = {sigs1, 3'b000};

  for (genvar k = 0; k < SHW; k++) begin : g_align
    localparam int SH = 1 << k;
    localparam logic [AW-1:0] MSK = {AW{1'b1}} >> (AW - SH);
    assign stg[k+1] = sh[k] ? ((stg[k] >> SH) | AW'(|(stg[k] & MSK))) : stg[k];
  end

  assign lng   = {1'b0, sigl1, 3'b000};
  assign shr   = {1'b0, stg[SHW]};
  assign sum_c = ctl1[W] ? lng - shr : lng + shr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl2 <= '0;
    else ctl2 <= ctl1;

  always_ff @(posedge clk) begin
    exp2 <= exp1;
    sum2 <= sum_c;
  end

  // ---------------- stage 3: leading one and normalize ----------------
  logic [SHW-1:0]       lz;
  logic [AW-1:0]        norm_m, m3;
  logic signed [XW-1:0] norm_e, e3;
  logic                 z3;

  always_comb begin
    lz = '0;
    for (int i = 0; i < AW; i++)
      if (sum2[i]) lz = SHW'(AW - 1 - i);
  end

  assign norm_m = sum2[SW-1] ? {sum2[SW-1:2], |sum2[1:0]} : (sum2[AW-1:0] << lz);
  assign norm_e = sum2[SW-1] ? {2'b00, exp2} + XW'(1) : {2'b00, exp2} - XW'(lz);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl3 <= '0;
    else ctl3 <= ctl2;

  always_ff @(posedge clk) begin
    m3 <= norm_m;
    e3 <= norm_e;
    z3 <= sum2 == '0;
  end

  // ---------------- stage 4: round, range check, pack ----------------
  logic                 rnd_up;
  logic [MW+1:0]        rnd;
  logic signed [XW-1:0] e4;
  logic [MW-1:0]        frac;
  logic [W-1:0]         res_c;
  logic                 inv_c, of_c, uf_c;

  assign rnd_up = m3[2] & (m3[1] | m3[0] | m3[3]);
  assign rnd    = {1'b0, m3[AW-1:3]} + (MW+2)'(rnd_up);
  assign e4     = e3 + XW'(rnd[MW+1]);
  assign frac   = rnd[MW+1] ? rnd[MW:1] : rnd[MW-1:0];

  always_comb begin
    res_c = '0;
    inv_c = 1'b0;
    of_c  = 1'b0;
    uf_c  = 1'b0;
    if (ctl3[W+3]) begin
      res_c = ctl3[W-1:0];
      inv_c = ctl3[W+2];
    end else if (z3) begin
      res_c = {ctl3[W+1] & ~ctl3[W], {(W-1){1'b0}}};
    end else if (e4 <= 0) begin
      res_c = {ctl3[W+1], {(W-1){1'b0}}};
      uf_c  = 1'b1;
    end else if (e4 >= $signed({2'b00, EMAX})) begin
      res_c = {ctl3[W+1], EMAX, {MW{1'b0}}};
      of_c  = 1'b1;
    end else begin
      res_c = {ctl3[W+1], e4[EW-1:0], frac};
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid      <= 1'b0;
      result         <= '0;
      flag_invalid   <= 1'b0;
      flag_overflow  <= 1'b0;
      flag_underflow <= 1'b0;
    end else begin
      out_valid      <= ctl3[W+4];
      result         <= res_c;
      flag_invalid   <= inv_c;
      flag_overflow  <= of_c;
      flag_underflow <= uf_c;
    end

  // ---------------- assertions ----------------
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 3'd4) age <= age + 3'd1;

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  assert_no_subnormal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !((result[W-2:MW] == '0) && (result[MW-1:0] != '0)));

  assert_underflow_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_underflow) |-> (result[W-2:0] == '0));

  assert_overflow_inf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_overflow) |-> (result[W-2:0] == {EMAX, {MW{1'b0}}}));

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_invalid, flag_overflow, flag_underflow}));

  assert_canon_nan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result[W-2:MW] == EMAX && result[MW-1:0] != '0) |-> (result == QNAN));

  assert_invalid_nan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_invalid) |-> (result == QNAN));
endmodule

// File: tb/test_ftz_fp_adder.sv
`timescale 1ns/1ps
module test_ftz_fp_adder;
  localparam int TEW = 5;
  localparam int TMW = 6;
  localparam int TW  = TEW + TMW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [TW-1:0] op_a = '0, op_b = '0;
  logic subtract = 1'b0;
  logic out_valid, flag_invalid, flag_overflow, flag_underflow;
  logic [TW-1:0] result;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  ftz_fp_adder #(.EW(TEW), .MW(TMW)) i_ftz_fp_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .subtract(subtract), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
    .flag_underflow(flag_underflow)
  );

  logic          e_v   [8];
  logic [TW-1:0] e_r   [8];
  logic [2:0]    e_f   [8];
  logic [TW-1:0] e_a   [8];
  logic [TW-1:0] e_b   [8];
  string         e_tag [8];

  localparam logic [TW-1:0] QN = {1'b0, {TEW{1'b1}}, 1'b1, {(TMW-1){1'b0}}};

  // exact integer reference: each normal value is sig << (exp-1) units
  task automatic ref_add(input logic [TW-1:0] a, input logic [TW-1:0] b, input logic sub,
                         output logic [TW-1:0] r, output logic [2:0] fl, output string tag);
    logic sa, sb, an, bn, ai, bi;
    logic [TEW-1:0] ea, eb;
    longint va, vb, tot, mag, q, rem, half;
    int p, e, shf;
    sa = a[TW-1]; sb = b[TW-1] ^ sub;
    ea = a[TW-2:TMW]; eb = b[TW-2:TMW];
    an = (&ea) && (a[TMW-1:0] != 0); bn = (&eb) && (b[TMW-1:0] != 0);
    ai = (&ea) && (a[TMW-1:0] == 0); bi = (&eb) && (b[TMW-1:0] == 0);
    fl = 3'b000;
    tag = (sub) ? "R11" : "R2";
    if (an || bn) begin r = QN; tag = "R6"; return; end
    if (ai && bi && sa != sb) begin r = QN; fl = 3'b100; tag = "R7"; return; end
    if (ai) begin r = {sa, {TEW{1'b1}}, {TMW{1'b0}}}; tag = "R8"; return; end
    if (bi) begin r = {sb, {TEW{1'b1}}, {TMW{1'b0}}}; tag = "R8"; return; end
    va = (ea == 0) ? 0 : (longint'({1'b1, a[TMW-1:0]}) << (ea - 1));
    vb = (eb == 0) ? 0 : (longint'({1'b1, b[TMW-1:0]}) << (eb - 1));
    if (sa) va = -va;
    if (sb) vb = -vb;
    tot = va + vb;
    if ((ea == 0 && a[TMW-1:0] != 0) || (eb == 0 && b[TMW-1:0] != 0)) tag = "R3";
    if (tot == 0) begin
      r = '0;
      if (ea == 0 && eb == 0 && sa == sb) r[TW-1] = sa;
      tag = "R9";
      return;
    end
    mag = (tot < 0) ? -tot : tot;
    p = 0;
    for (int i = 0; i < 62; i++) if (mag[i]) p = i;
    e = p - TMW + 1;
    if (p > TMW) begin
      shf = p - TMW;
      q = mag >> shf;
      rem = mag & ((64'd1 << shf) - 1);
      half = 64'd1 << (shf - 1);
      if (rem > half || (rem == half && q[0])) q = q + 1;
      if (q == (64'd1 << (TMW + 1))) begin q = q >> 1; e = e + 1; end
    end else begin
      q = mag << (TMW - p);
    end
    if (e < 1) begin
      r = {tot < 0, {(TW-1){1'b0}}}; fl = 3'b001; tag = "R4";
    end else if (e >= (1 << TEW) - 1) begin
      r = {tot < 0, {TEW{1'b1}}, {TMW{1'b0}}}; fl = 3'b010; tag = "R5";
    end else begin
      r = {tot < 0, TEW'(e), q[TMW-1:0]};
    end
  endtask

  task automatic check_slot(input int s);
    logic ok;
    checks++;
    ok = (out_valid === e_v[s]);
    if (ok && e_v[s])
      ok = (result === e_r[s]) && ({flag_invalid, flag_overflow, flag_underflow} === e_f[s]);
    if (!ok) begin
      fails++;
      $display("FAIL %s (R1 timing) a=%h b=%h: valid=%b result=%h flags=%b, expected valid=%b result=%h flags=%b",
               e_tag[s], e_a[s], e_b[s], out_valid, result,
               {flag_invalid, flag_overflow, flag_underflow}, e_v[s], e_r[s], e_f[s]);
    end
  endtask

  task automatic step(input logic v, input logic [TW-1:0] a, input logic [TW-1:0] b, input logic sub);
    logic [TW-1:0] r;
    logic [2:0] f;
    string t;
    int s;
    @(negedge clk);
    check_slot((cyc + 4) & 7);
    in_valid = v; op_a = a; op_b = b; subtract = sub;
    s = cyc & 7;
    e_v[s] = v; e_a[s] = a; e_b[s] = b;
    if (v) begin
      ref_add(a, b, sub, r, f, t);
      e_r[s] = r; e_f[s] = f; e_tag[s] = t;
    end else begin
      e_r[s] = '0; e_f[s] = '0; e_tag[s] = "R1";
    end
    cyc++;
  endtask

  function automatic logic [TW-1:0] special(input int k);
    case (k & 7)
      0: return 12'h000;
      1: return 12'h800;
      2: return 12'h7C0;
      3: return 12'hFC0;
      4: return 12'h7E1;
      5: return 12'h005;
      6: return 12'h7BF;
      default: return 12'h040;
    endcase
  endfunction

  initial begin
    for (int s = 0; s < 8; s++) begin
      e_v[s] = 1'b0; e_r[s] = '0; e_f[s] = '0; e_a[s] = '0; e_b[s] = '0; e_tag[s] = "R1";
    end
    repeat (3) @(negedge clk);
    // R10: reset state at the ports
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || flag_invalid !== 1'b0 ||
        flag_overflow !== 1'b0 || flag_underflow !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: valid=%b result=%h flags=%b%b%b, expected all zero",
               out_valid, result, flag_invalid, flag_overflow, flag_underflow);
    end
    rst_n = 1'b1;
    for (int i = 0; i < (1 << TW); i++) begin
      for (int j = 0; j < 36; j++) begin
        logic [TW-1:0] a, b;
        a = TW'(i);
        if (j == 0)       step(1'b1, a, a, 1'b1);
        else if (j == 1)  step(1'b1, a, a, 1'b0);
        else if (j == 34) step(1'b1, a, special(i), a[3]);
        else if (j == 35) step(1'b0, a, a, 1'b0);
        else begin
          b = TW'(i * 7 + j * 397 + j * j * 29);
          step(1'b1, a, b, j[0]);
        end
      end
    end
    for (int k = 0; k < 6; k++) step(1'b0, '0, '0, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual cycles=%0d expected fewer", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule